// File: doc/BRIEF.md
# Neighbour Population Counter and Life Rule

This block evaluates one cell of a two-state cellular automaton that follows the usual birth/survival rule. It takes the eight neighbour states and the present state of the centre cell. A balanced tree of small adders counts the live neighbours. At each level of the tree the adders widen by one bit: 1 to 2, then 2 to 3, then 3 to 4. Two equality detectors compare the final 4-bit total with two and with three. A small rule stage combines those flags with the centre state to form the cell's state for the next generation.

Storing the grid, handling the edges and stepping through generations are left to the surrounding logic. A generate switch (`OUT_REG`) places a register on the outputs for timing, and it is enabled by default. With the register in place, every result appears one clock after its inputs. An active-low asynchronous reset clears the register.

Top module: `life_cell_eval`

## Requirements
- R1: While `rst_n` is low, all outputs (`live_cnt`, `is_two`, `is_three`, `alive_next`) are zero.
- R2: `live_cnt` equals the number of set bits in `nbr`, for all 256 neighbour patterns.
- R3: `live_cnt` does not depend on `centre`. Any neighbour pattern gives the same count with `centre` at 0 and at 1.
- R4: `is_two` is high exactly when the neighbour count is 2.
- R5: `is_three` is high exactly when the neighbour count is 3.
- R6: `is_two` and `is_three` are never high in the same cycle.
- R7: `alive_next` is 1 whenever the neighbour count is 3, whatever the value of `centre`.
- R8: With a neighbour count of 2, `alive_next` equals `centre`.
- R9: For neighbour counts of 0, 1 and 4 through 8, `alive_next` is 0.
- R10: With `OUT_REG`=1, outputs change only at a rising clock edge and reflect the inputs present at that edge. They hold between edges even when the inputs change.
- R11: `live_cnt` never exceeds 8.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Asynchronous active-low reset |
| nbr | input | 8 | Neighbour states, one bit per neighbour, 1 = alive |
| centre | input | 1 | Present state of the centre cell, 1 = alive |
| live_cnt | output | 4 | Number of live neighbours, 0 to 8 |
| is_two | output | 1 | High when the count is exactly 2 |
| is_three | output | 1 | High when the count is exactly 3 |
| alive_next | output | 1 | Centre cell state for the next generation |

## Verification
The bench applies all 512 combinations of the neighbour byte and the centre bit, one per clock. This covers every count from 0 to 8 at every bit placement, so a mis-wired adder input or a dropped carry at any tree level shows up as a wrong count. Running each neighbour byte with `centre` at both values separates the survive case (count 2, centre alive) from the stay-dead case. It also shows that the count and the flags ignore the centre. The patterns with one, two, three and four bits set cover the edges of the rule: birth at three, survival only at two or three, and death at four. After each input change, a check taken between clock edges shows that the registered outputs still hold the previous result.

// File: rtl/life_pkg.sv
`timescale 1ns/1ps
package life_pkg;
    localparam int NBR_N = 8;
    localparam int CNT_W = $clog2(NBR_N) + 1;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             eq2;
        logic             eq3;
        logic             nxt;
    } cell_res_t;
endpackage

// File: rtl/pair_adder.sv
`timescale 1ns/1ps
module pair_adder #(
    parameter int W = 1
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W:0]   s
);
    assign s = {1'b0, a} + {1'b0, b};
endmodule

// File: rtl/pop_tree.sv
`timescale 1ns/1ps
module pop_tree #(
    parameter int N = 8
) (
    input  logic [N-1:0]         in_bits,
    output logic [$clog2(N):0]   total
);
    localparam int LVLS = $clog2(N);

    for (genvar l = 0; l <= LVLS; l++) begin : g_lvl
        localparam int NODES = N >> l;
        logic [NODES-1:0][l:0] sums;
        if (l == 0) begin : g_leaf
            for (genvar i = 0; i < NODES; i++) begin : g_in
                assign sums[i] = in_bits[i];
            end
        end else begin : g_add
            for (genvar i = 0; i < NODES; i++) begin : g_node
                pair_adder #(.W(l)) u_add (
                    .a (g_lvl[l-1].sums[2*i]),
                    .b (g_lvl[l-1].sums[2*i+1]),
                    .s (sums[i])
                );
            end
        end
    end

    assign total = g_lvl[LVLS].sums[0];
endmodule

// File: rtl/life_rule.sv
`timescale 1ns/1ps
module life_rule #(
    parameter int CW = 4
) (
    input  logic [CW-1:0] cnt,
    input  logic          centre,
    output logic          eq2,
    output logic          eq3,
    output logic          nxt
);
    assign eq2 = (cnt == CW'(2));
    assign eq3 = (cnt == CW'(3));
    assign nxt = eq3 | (eq2 & centre);
endmodule

// File: rtl/life_cell_eval.sv
`timescale 1ns/1ps
module life_cell_eval #(
    parameter bit OUT_REG = 1'b1
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [life_pkg::NBR_N-1:0]  nbr,
    input  logic                        centre,
    output logic [life_pkg::CNT_W-1:0]  live_cnt,
    output logic                        is_two,
    output logic                        is_three,
    output logic                        alive_next
);
    import life_pkg::*;

    logic [CNT_W-1:0] tree_cnt;
    logic             f2, f3, fn;
    cell_res_t        res_d, res_q;

    pop_tree #(.N(NBR_N)) u_tree (
        .in_bits (nbr),
        .total   (tree_cnt)
    );

    life_rule #(.CW(CNT_W)) u_rule (
        .cnt    (tree_cnt),
        .centre (centre),
        .eq2    (f2),
        .eq3    (f3),
        .nxt    (fn)
    );

    always_comb begin
        res_d     = '0;
        res_d.cnt = tree_cnt;
        res_d.eq2 = f2;
        res_d.eq3 = f3;
        res_d.nxt = fn;
    end

    if (OUT_REG) begin : g_reg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) res_q <= '0;
            else        res_q <= res_d;
        end
    end else begin : g_comb
        assign res_q = res_d;
    end

    assign live_cnt   = res_q.cnt;
    assign is_two     = res_q.eq2;
    assign is_three   = res_q.eq3;
    assign alive_next = res_q.nxt;
endmodule

// File: rtl/life_cell_eval_chk.sv
`timescale 1ns/1ps
module life_cell_eval_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [7:0] nbr,
    input logic       centre,
    input logic [3:0] live_cnt,
    input logic       is_two,
    input logic       is_three,
    input logic       alive_next
);
    // R2
    count_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (32'(live_cnt) == $past($countones(nbr))));
    // R4
    two_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (is_two == ($past($countones(nbr)) == 2)));
    // R5
    three_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (is_three == ($past($countones(nbr)) == 3)));
    // R6
    flags_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(is_two && is_three));
    // R7
    birth_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past($countones(nbr)) == 3) |-> alive_next);
    // R8
    survive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past($countones(nbr)) == 2) |-> (alive_next == $past(centre)));
    // R9
    death_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past($countones(nbr)) != 2 && $past($countones(nbr)) != 3) |-> !alive_next);
    // R11
    count_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        live_cnt <= 4'd8);
endmodule

bind life_cell_eval life_cell_eval_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .nbr        (nbr),
    .centre     (centre),
    .live_cnt   (live_cnt),
    .is_two     (is_two),
    .is_three   (is_three),
    .alive_next (alive_next)
);

// File: tb/tb_life_cell_eval.sv
`timescale 1ns/1ps
module tb_life_cell_eval;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] nbr = 8'hFF;
    logic       centre = 1'b1;
    logic [3:0] live_cnt;
    logic       is_two, is_three, alive_next;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    typedef struct {
        int cnt; bit e2; bit e3; bit nx; bit c;
    } exp_t;
    exp_t sb[$];
    int   last_cnt = 0;

    always #2 clk = ~clk;

    life_cell_eval dut (
        .clk(clk), .rst_n(rst_n), .nbr(nbr), .centre(centre),
        .live_cnt(live_cnt), .is_two(is_two), .is_three(is_three),
        .alive_next(alive_next)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d (nbr=%02h centre=%0b)",
                     tag, act, exp, nbr, centre);
        end
    endtask

    function automatic exp_t model(input logic [7:0] nb, input logic c);
        exp_t e;
        int k = 0;
        for (int i = 0; i < 8; i++) if (nb[i]) k++;
        e.cnt = k;
        e.e2  = (k == 2);
        e.e3  = (k == 3);
        e.nx  = (k == 3) || (k == 2 && c);
        e.c   = c;
        return e;
    endfunction

    task automatic apply(input logic [7:0] nb, input logic c);
        @(negedge clk);
        nbr    = nb;
        centre = c;
        #1;
        check("R10 hold between edges", int'(live_cnt), last_cnt);
        sb.push_back(model(nb, c));
    endtask

    // monitor
    always begin
        @(posedge clk);
        #1;
        if (sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            check(e.c ? "R2/R3 count (centre=1)" : "R2 count", int'(live_cnt), e.cnt);
            check("R4 is_two", int'(is_two), int'(e.e2));
            check("R5 is_three", int'(is_three), int'(e.e3));
            check("R6 flags exclusive", int'(is_two & is_three), 0);
            check("R11 count range", int'(live_cnt > 4'd8), 0);
            if (e.cnt == 3)      check("R7 birth/survive", int'(alive_next), 1);
            else if (e.cnt == 2) check("R8 survive follows centre", int'(alive_next), int'(e.c));
            else                 check("R9 dies", int'(alive_next), 0);
            last_cnt = e.cnt;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 reset cnt", int'(live_cnt), 0);
        check("R1 reset is_two", int'(is_two), 0);
        check("R1 reset is_three", int'(is_three), 0);
        check("R1 reset alive_next", int'(alive_next), 0);
        nbr = 8'h00;
        centre = 1'b0;
        rst_n = 1'b1;
        repeat (2) @(posedge clk);
        for (int c = 0; c < 2; c++)
            for (int v = 0; v < 256; v++)
                apply(8'(v), c[0]);
        repeat (3) @(posedge clk);
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            done = 1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule